// File: doc/BRIEF.md
# Tick-Timed PWM Channel

This block drives one pulse-width modulated output from two 16-bit settings: a cycle time and an on time, both counted in ticks of a time base. A single-cycle `tick_en` strobe, generated elsewhere from the system clock (one pulse per 100 ns in the intended use), paces a period counter. Inside each period the output is high for the first on-time ticks and low for the remainder.

Software may rewrite the settings at any moment. The block copies them into working registers only on the tick that closes a period, so every period runs with one consistent pair and never produces a truncated pulse. Two cycle-time codes are reserved. Code 1 parks the output low. Code 0 selects the longest period of 65535 ticks, where a literal reading would give a zero-length period. Any other value n gives a period of n ticks. The documented usable range is 400 to 32767 ticks, but the block does not enforce it.

Top module: `pwm_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output goes low, the period counter clears and the active cycle code becomes the park code (1). The first tick after release therefore loads the input settings.
- R2: An active cycle code n in the range 2 to 65535 gives a period of exactly n ticks. The smallest case exercised is n = 3.
- R3: Within a period, `pwm_out` is high for the first on-time ticks and low for the remaining ticks. It rises only when a new period starts.
- R4: If the active on time is greater than or equal to the active period, `pwm_out` stays high continuously.
- R5: An active on time of 0 keeps `pwm_out` low continuously.
- R6: While the active cycle code is 1, `pwm_out` is low whatever the on time. Every tick closes a period in this state, so new settings take effect on the next tick.
- R7: An active cycle code of 0 gives a period of 65535 ticks.
- R8: `cycle_time` and `on_time` are sampled only on the tick that ends a period. Changes made partway through a period have no effect on that period.
- R9: Without `tick_en`, the period counter, the working settings and `pwm_out` all hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle time-base strobe; each pulse is one tick |
| cycle_time | input | 16 | Requested period in ticks (0 = longest, 1 = parked low) |
| on_time | input | 16 | Requested high time in ticks |
| pwm_out | output | 1 | Modulated output |

## Verification
Five behaviours are checked by assertions on every clock: the counter stays inside the active period, the parked state holds the counter at zero, the working settings change only when the counter restarts at zero, rising edges occur only at period start, and the state freezes when no tick arrives. The pulse lengths that result from given settings can only be shown by the bench's scenarios, which measure high and low times in ticks and compare the output against a behavioural model on every clock. These scenarios include the longest-period code, the parked code and the exit from it, the on time at or above the period, a zero on time, and a rewrite partway through a period.

// File: rtl/pwm_pkg.sv
// Shared definitions for the PWM channel.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package pwm_pkg;

    // Operating state decoded from the active cycle code
    typedef enum logic {
        PWM_RUN  = 1'b0,
        PWM_PARK = 1'b1
    } pwm_mode_e;

endpackage

// File: rtl/pwm_shadow.sv
// Working copy of the cycle and on settings.
// What it does: captures the requested settings when load_en is high and
// holds them otherwise.
// Assumes: load_en is asserted only on the tick that closes a period.
module pwm_shadow #(
    parameter int          W        = 16,
    parameter int unsigned OFF_CODE = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] cyc_req,
    input  logic [W-1:0] on_req,
    output logic [W-1:0] act_cyc,
    output logic [W-1:0] act_on
);

    // Capture the requested pair at a period boundary; reset into the park code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cyc <= W'(OFF_CODE);
            act_on  <= '0;
        end else if (load_en) begin
            act_cyc <= cyc_req;
            act_on  <= on_req;
        end
    end

endmodule

// File: rtl/pwm_period_decode.sv
// Cycle-code decoder.
// What it does: turns the active cycle code into an operating mode and the
// index of the last tick of the period. The park code maps to a one-tick
// period with the output held low. The max code maps to the all-ones period.
// Assumes: OFF_CODE and MAX_CODE differ.
module pwm_period_decode
    import pwm_pkg::*;
#(
    parameter int          W        = 16,
    parameter int unsigned OFF_CODE = 1,
    parameter int unsigned MAX_CODE = 0
) (
    input  logic [W-1:0] act_cyc,
    output pwm_mode_e    mode,
    output logic [W-1:0] last_idx
);

    localparam logic [W-1:0] LONG_LAST = {W{1'b1}} - 1'b1;

    // Map reserved codes to their special meaning; other codes count literally
    always_comb begin
        mode     = PWM_RUN;
        last_idx = act_cyc - 1'b1;
        if (act_cyc == W'(OFF_CODE)) begin
            mode     = PWM_PARK;
            last_idx = '0;
        end else if (act_cyc == W'(MAX_CODE)) begin
            last_idx = LONG_LAST;
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
// Period counter and output compare.
// What it does: advances the tick counter on each tick_en. It wraps to zero
// after the last tick, or on every tick while parked, and flags the wrap as a
// load request. The output is high while the count is below the on time.
// Assumes: tick_en is a single-cycle strobe.
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  pwm_mode_e    mode,
    input  logic [W-1:0] last_idx,
    input  logic [W-1:0] act_on,
    output logic [W-1:0] cnt,
    output logic         load_en,
    output logic         pwm_out
);

    logic wrap;

    // Period ends on the last index, or on every tick while parked
    always_comb begin
        wrap    = (mode == PWM_PARK) || (cnt == last_idx);
        load_en = tick_en && wrap;
    end

    // Tick counter: restart at a boundary, otherwise count up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick_en) begin
            if (wrap) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Output compare, driven only from registered state
    always_comb begin
        pwm_out = (mode == PWM_RUN) && (cnt < act_on);
    end

endmodule

// File: rtl/pwm_channel.sv
// Top of the PWM channel.
// What it does: joins the working-setting registers, the cycle-code decoder
// and the period counter into one tick-paced PWM output.
// Assumes: the tick strobe comes from an external divider of clk; the
// settings are quasi-static registers written by a host.
module pwm_channel #(
    parameter int          W        = 16,
    parameter int unsigned OFF_CODE = 1,
    parameter int unsigned MAX_CODE = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic [W-1:0] cycle_time,
    input  logic [W-1:0] on_time,
    output logic         pwm_out
);

    import pwm_pkg::*;

    logic [W-1:0] act_cyc;
    logic [W-1:0] act_on;
    logic [W-1:0] cnt_q;
    logic [W-1:0] last_idx;
    logic         load_en;
    pwm_mode_e    mode;

    pwm_shadow #(
        .W        (W),
        .OFF_CODE (OFF_CODE)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .cyc_req (cycle_time),
        .on_req  (on_time),
        .act_cyc (act_cyc),
        .act_on  (act_on)
    );

    pwm_period_decode #(
        .W        (W),
        .OFF_CODE (OFF_CODE),
        .MAX_CODE (MAX_CODE)
    ) u_decode (
        .act_cyc  (act_cyc),
        .mode     (mode),
        .last_idx (last_idx)
    );

    pwm_timebase #(
        .W (W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .mode     (mode),
        .last_idx (last_idx),
        .act_on   (act_on),
        .cnt      (cnt_q),
        .load_en  (load_en),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm_channel_chk.sv
// Assertion checker for pwm_channel, attached by bind.
// What it does: checks counter range, parking, load timing, edge placement
// and hold behaviour over time.
// Assumes: reset is asserted from time zero.
module pwm_channel_chk #(
    parameter int          W        = 16,
    parameter int unsigned OFF_CODE = 1,
    parameter int unsigned MAX_CODE = 0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic         pwm_out,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_cyc,
    input logic [W-1:0] act_on
);

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (!pwm_out && cnt == '0 && act_cyc == W'(OFF_CODE))) // R1
        else $error("reset state wrong");

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cyc != W'(OFF_CODE) && act_cyc != W'(MAX_CODE)) |-> (cnt < act_cyc)) // R2
        else $error("count outside period");

    AST_PARK_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cyc == W'(OFF_CODE)) |-> (cnt == '0 && !pwm_out)) // R6
        else $error("parked state not idle");

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (cnt == '0)) // R3
        else $error("rising edge inside period");

    AST_LOAD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_cyc) || !$stable(act_on)) |-> (cnt == '0)) // R8
        else $error("settings changed mid-period");

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(cnt) && $stable(pwm_out) && $stable(act_cyc))) // R9
        else $error("state moved without tick");

endmodule

bind pwm_channel pwm_channel_chk #(
    .W        (W),
    .OFF_CODE (OFF_CODE),
    .MAX_CODE (MAX_CODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .pwm_out (pwm_out),
    .cnt     (cnt_q),
    .act_cyc (act_cyc),
    .act_on  (act_on)
);

// File: tb/sim_pwm_channel.sv
// Bench for pwm_channel: a behavioural model compared every clock, plus
// scenario checks that measure high and low times in ticks.
module sim_pwm_channel;

    localparam int W = 16;

    logic         clk     = 1'b0;
    logic         rst_n   = 1'b0;
    logic         tick_en = 1'b0;
    logic [W-1:0] cyc_in  = '0;
    logic [W-1:0] on_in   = '0;
    logic         pwm_out;

    int tick_div = 0;
    int errors   = 0;
    int checks   = 0;
    int m_cnt    = 0;
    int m_cyc    = 1;
    int m_on     = 0;
    int m_per    = 0;
    int m_exp    = 0;
    bit m_valid  = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pwm_channel #(.W(W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .cycle_time (cyc_in),
        .on_time    (on_in),
        .pwm_out    (pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Sample point: 4 ns after the rising edge, well clear of both edges
    task automatic smp();
        @(posedge clk);
        #4;
    endtask

    // Tick strobe generator, updated on falling edges
    initial begin
        int dc = 0;
        forever begin
            @(negedge clk);
            if (tick_div == 0) begin
                tick_en = 1'b0;
                dc = 0;
            end else if (dc >= tick_div - 1) begin
                tick_en = 1'b1;
                dc = 0;
            end else begin
                tick_en = 1'b0;
                dc++;
            end
        end
    end

    // Behavioural reference model, compared on every clock (R2 R3 R4 R5 R6 R7 R8 R9)
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cyc = 1; m_on = 0; m_valid = 1'b1;
        end else if (tick_en) begin
            m_per = (m_cyc == 0) ? 65535 : m_cyc;
            if (m_cyc == 1 || m_cnt == m_per - 1) begin
                m_cnt = 0; m_cyc = int'(cyc_in); m_on = int'(on_in);
            end else begin
                m_cnt++;
            end
        end
        #4;
        if (m_valid && rst_n) begin
            m_exp = (m_cyc != 1 && m_cnt < m_on) ? 1 : 0;
            check(int'(pwm_out) == m_exp, "model R3", int'(pwm_out), m_exp);
        end
    end

    // Measure one whole period starting at the next rising edge, in ticks
    task automatic measure(output int hi, output int lo);
        bit prev;
        int h = 0;
        int l = 0;
        smp();
        prev = pwm_out;
        while (!(prev == 1'b0 && pwm_out == 1'b1)) begin
            prev = pwm_out;
            smp();
        end
        while (pwm_out == 1'b1) begin h++; smp(); end
        while (pwm_out == 1'b0) begin l++; smp(); end
        hi = h / tick_div;
        lo = l / tick_div;
    endtask

    task automatic hold_level(input bit lvl, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            smp();
            if (pwm_out !== lvl) bad++;
        end
        check(bad == 0, req, bad, 0);
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) smp();
    endtask

    initial begin
        int hi;
        int lo;
        cyc_in = 16'd400;
        on_in  = 16'd100;
        wait_clks(3);
        check(pwm_out === 1'b0, "R1 output low in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        hold_level(1'b0, 3, "R1 low after release before first tick");
        tick_div = 5;

        // Basic period
        measure(hi, lo);
        check(hi == 100, "R3 high ticks", hi, 100);
        check(lo == 300, "R2 low ticks for period 400", lo, 300);

        // Rewrite right after a period starts: old values must finish the period
        cyc_in = 16'd600;
        on_in  = 16'd300;
        wait_clks(150 * 5);
        check(pwm_out === 1'b0, "R8 current period keeps old on time", int'(pwm_out), 0);
        measure(hi, lo);
        check(hi == 300, "R8 new on time after boundary", hi, 300);
        check(lo == 300, "R8 new period after boundary", lo, 300);

        // On time equal to period
        cyc_in = 16'd500;
        on_in  = 16'd500;
        wait_clks(700 * 5);
        hold_level(1'b1, 1200 * 5, "R4 on time equal to period stays high");

        // Zero on time
        cyc_in = 16'd400;
        on_in  = 16'd0;
        wait_clks(700 * 5);
        hold_level(1'b0, 900 * 5, "R5 zero on time stays low");

        // Park code, then leave it
        cyc_in = 16'd1;
        on_in  = 16'd200;
        wait_clks(500 * 5);
        hold_level(1'b0, 500 * 5, "R6 park code holds low");
        cyc_in = 16'd400;
        on_in  = 16'd50;
        wait_clks(3 * 5);
        check(pwm_out === 1'b1, "R6 leaving park at next tick", int'(pwm_out), 1);

        // Ticks stopped partway through the high phase
        tick_div = 0;
        wait_clks(2);
        hold_level(1'b1, 3000, "R9 output frozen without ticks");
        tick_div = 5;

        // Short period at one tick per clock
        tick_div = 1;
        cyc_in = 16'd3;
        on_in  = 16'd1;
        measure(hi, lo);
        check(hi == 1, "R2 period 3 high ticks", hi, 1);
        check(lo == 2, "R2 period 3 low ticks", lo, 2);

        // Longest period code
        cyc_in = 16'd0;
        on_in  = 16'd1000;
        measure(hi, lo);
        check(hi == 1000, "R7 high ticks in longest period", hi, 1000);
        check(hi + lo == 65535, "R7 longest period length", hi + lo, 65535);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1 run did not finish: actual=%0d expected=%0d", 190000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule